// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This unit keeps a 15-bit program counter and, once per accepted operation, works out where execution goes next. It covers plain sequential stepping and four kinds of control transfer: a short signed hop relative to the current count, a jump inside the current 4K-word segment, a long jump anywhere in the 32K-word space, and a two-step jump through a byte table held in program memory and indexed by the accumulator.

The instruction decoder presents a mode code, the instruction's address field and the accumulator value, qualified by a valid strobe. Most modes take effect at the next clock edge. The table jump takes two edges. After the first edge the unit raises a busy flag and drives the table address. During the busy cycle the memory returns the table byte on `pm_data`, and the second edge loads that byte into the low eight bits of the count.

Top module: `pc_next_unit`

## Requirements
- R1: While reset is held, `pc` is 0, `busy` is 0 and `bad_disp` is 0.
- R2: When `busy` is 0 and `op_valid` is 0, `pc` keeps its value across the clock edge.
- R3: Mode code 0 (sequential) sets `pc` to `pc + 1` modulo 2^15, so 0x7FFF steps to 0x0000.
- R4: Mode code 1 (relative) reads a 6-bit value f from `op_field[5:0]` and sets `pc` to `pc + f - 31` modulo 2^15. This gives a reach of -31 (f = 0) to +32 (f = 63). Page and segment boundaries do not limit it.
- R5: A relative operation with f = 31 (offset 0) or f = 32 (offset +1) is illegal. It advances `pc` by one, and `bad_disp` is 1 for the cycle after that edge. `bad_disp` is 0 after every other accepted or ignored edge.
- R6: Mode code 2 (segment jump) keeps `pc[14:12]` and loads `pc[11:0]` from `op_field[11:0]`.
- R7: Mode code 3 (long jump) loads all 15 bits of `pc` from `op_field[14:0]`.
- R8: Mode code 4 (table jump) leaves `pc` unchanged at the first edge. After that edge, `busy` is 1 and `tbl_addr` equals `{pc[14:8], acc}`.
- R9: At the edge that ends a busy cycle, `pc` becomes `{pc[14:8], pm_data}` and `busy` returns to 0.
- R10: While `busy` is 1, `op_valid`, `op_mode`, `op_field` and `acc` have no effect. The resulting `pc` depends only on `pm_data`.
- R11: The reserved mode codes 5, 6 and 7 leave `pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 3 | Mode code: 0 sequential, 1 relative, 2 segment, 3 long, 4 table, 5-7 reserved |
| op_field | input | 15 | Instruction address field |
| acc | input | 8 | Accumulator, used as the table index |
| pm_data | input | 8 | Program memory byte read at `tbl_addr` during the busy cycle |
| pc | output | 15 | Current program counter |
| busy | output | 1 | Table read in progress; new operations are ignored |
| tbl_addr | output | 15 | Program memory address of the table byte |
| bad_disp | output | 1 | The last accepted relative operation had an illegal offset |

## Verification
Every result except the table byte load is due one clock edge after the operation is presented. The table jump shows `busy` and `tbl_addr` one edge after it is accepted, and the loaded `pc` one edge after that. The bench drives each cycle's inputs at the falling edge and queues the value it expects to see after the next rising edge. A monitor then compares each queued item 1 ns after that rising edge, so each item is checked in exactly the cycle its register updates.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
    typedef enum logic [2:0] {
        MODE_SEQ  = 3'd0,
        MODE_REL  = 3'd1,
        MODE_ABS  = 3'd2,
        MODE_LONG = 3'd3,
        MODE_IND  = 3'd4
    } pc_mode_e;
endpackage

// File: rtl/pcnu_rel_calc.sv
module pcnu_rel_calc #(
    parameter int PC_W  = 15,
    parameter int REL_W = 6
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [REL_W-1:0] disp_f,
    output logic [PC_W-1:0]  rel_pc,
    output logic             rel_bad
);
    // field value that stands for an offset of zero
    localparam int BIAS = (1 << (REL_W - 1)) - 1;

    always_comb begin
        rel_pc  = base_pc + PC_W'(disp_f) - PC_W'(BIAS);
        rel_bad = (disp_f == REL_W'(BIAS)) || (disp_f == REL_W'(BIAS + 1));
    end
endmodule

// File: rtl/pcnu_tgt_mux.sv
module pcnu_tgt_mux
    import pcnu_pkg::*;
#(
    parameter int PC_W  = 15,
    parameter int SEG_W = 12
) (
    input  logic [2:0]      mode,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] field,
    input  logic [PC_W-1:0] rel_pc,
    input  logic            rel_bad,
    output logic [PC_W-1:0] nxt_pc,
    output logic            start_tbl,
    output logic            flag_bad
);
    localparam int HI_W = PC_W - SEG_W;

    always_comb begin
        nxt_pc    = cur_pc;
        start_tbl = 1'b0;
        flag_bad  = 1'b0;
        case (mode)
            MODE_SEQ:  nxt_pc = cur_pc + PC_W'(1);
            MODE_REL: begin
                if (rel_bad) begin
                    nxt_pc   = cur_pc + PC_W'(1);
                    flag_bad = 1'b1;
                end else begin
                    nxt_pc = rel_pc;
                end
            end
            MODE_ABS:  nxt_pc = {cur_pc[PC_W-1 -: HI_W], field[SEG_W-1:0]};
            MODE_LONG: nxt_pc = field;
            MODE_IND:  start_tbl = 1'b1;
            default:   nxt_pc = cur_pc;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
    parameter int PC_W     = 15,
    parameter int SEG_W    = 12,
    parameter int BYTE_W   = 8,
    parameter int REL_W    = 6,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_mode,
    input  logic [PC_W-1:0]   op_field,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] pm_data,
    output logic [PC_W-1:0]   pc,
    output logic              busy,
    output logic [PC_W-1:0]   tbl_addr,
    output logic              bad_disp
);
    localparam int UP_W = PC_W - BYTE_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            busy;
        logic [PC_W-1:0] tbl_addr;
        logic            bad;
    } pcnu_state_t;

    pcnu_state_t st_d, st_q;

    logic [PC_W-1:0] rel_pc, mux_pc;
    logic            rel_bad, start_tbl, mux_bad;

    pcnu_rel_calc #(.PC_W(PC_W), .REL_W(REL_W)) u_rel (
        .base_pc (st_q.pc),
        .disp_f  (op_field[REL_W-1:0]),
        .rel_pc  (rel_pc),
        .rel_bad (rel_bad)
    );

    pcnu_tgt_mux #(.PC_W(PC_W), .SEG_W(SEG_W)) u_mux (
        .mode      (op_mode),
        .cur_pc    (st_q.pc),
        .field     (op_field),
        .rel_pc    (rel_pc),
        .rel_bad   (rel_bad),
        .nxt_pc    (mux_pc),
        .start_tbl (start_tbl),
        .flag_bad  (mux_bad)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (st_q.busy) begin
            st_d.pc   = {st_q.pc[PC_W-1 -: UP_W], pm_data};
            st_d.busy = 1'b0;
        end else if (op_valid) begin
            st_d.pc  = mux_pc;
            st_d.bad = mux_bad;
            if (start_tbl) begin
                st_d.busy     = 1'b1;
                st_d.tbl_addr = {st_q.pc[PC_W-1 -: UP_W], acc};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pc: PC_W'(RESET_PC), busy: 1'b0, tbl_addr: '0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pc       = st_q.pc;
    assign busy     = st_q.busy;
    assign tbl_addr = st_q.tbl_addr;
    assign bad_disp = st_q.bad;
endmodule

// File: rtl/pcnu_chk.sv
module pcnu_chk #(
    parameter int PC_W   = 15,
    parameter int SEG_W  = 12,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_mode,
    input logic [PC_W-1:0]   op_field,
    input logic [BYTE_W-1:0] acc,
    input logic [BYTE_W-1:0] pm_data,
    input logic [PC_W-1:0]   pc,
    input logic              busy,
    input logic [PC_W-1:0]   tbl_addr,
    input logic              bad_disp
);
    localparam int UP_W = PC_W - BYTE_W;
    localparam int HI_W = PC_W - SEG_W;

    logic acc_ok;
    assign acc_ok = op_valid && !busy;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !busy) |=> (pc == $past(pc)));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_mode == 3'd0) |=> (pc == PC_W'($past(pc) + PC_W'(1))));

    // R5
    bad_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_mode == 3'd1 && (op_field[5:0] == 6'd31 || op_field[5:0] == 6'd32))
        |=> (bad_disp && pc == PC_W'($past(pc) + PC_W'(1))));

    // R6
    seg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_mode == 3'd2) |=>
        (pc[PC_W-1 -: HI_W] == $past(pc[PC_W-1 -: HI_W]) &&
         pc[SEG_W-1:0] == $past(op_field[SEG_W-1:0])));

    // R8
    tbl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_mode == 3'd4) |=>
        (busy && pc == $past(pc) && tbl_addr == {$past(pc[PC_W-1 -: UP_W]), $past(acc)}));

    // R9
    tbl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && pc[BYTE_W-1:0] == $past(pm_data) &&
                  pc[PC_W-1 -: UP_W] == $past(pc[PC_W-1 -: UP_W])));

    // R11
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_mode >= 3'd5) |=> (pc == $past(pc)));
endmodule

bind pc_next_unit pcnu_chk #(.PC_W(PC_W), .SEG_W(SEG_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_mode  (op_mode),
    .op_field (op_field),
    .acc      (acc),
    .pm_data  (pm_data),
    .pc       (pc),
    .busy     (busy),
    .tbl_addr (tbl_addr),
    .bad_disp (bad_disp)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_mode = 3'd0;
    logic [14:0] op_field = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  pm_data = '0;
    logic [14:0] pc;
    logic        busy;
    logic [14:0] tbl_addr;
    logic        bad_disp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [14:0] pc;
        logic        busy;
        logic        bad;
        logic [14:0] tadr;
        bit          chk_tadr;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    logic [14:0] m_pc = '0;
    logic        m_busy = 1'b0;

    always #2.5 clk = ~clk;

    pc_next_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_field(op_field), .acc(acc), .pm_data(pm_data), .pc(pc),
        .busy(busy), .tbl_addr(tbl_addr), .bad_disp(bad_disp)
    );

    task automatic check(input string req, input string what, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] m, input logic [14:0] f,
                        input logic [7:0] a, input logic [7:0] pd, input string req);
        exp_t e;
        @(negedge clk);
        op_valid = v; op_mode = m; op_field = f; acc = a; pm_data = pd;
        e.bad = 1'b0; e.chk_tadr = 1'b0; e.tadr = '0; e.req = req;
        if (m_busy) begin
            m_pc = {m_pc[14:8], pd};
            m_busy = 1'b0;
        end else if (v) begin
            case (m)
                3'd0: m_pc = m_pc + 15'd1;
                3'd1: begin
                    if (f[5:0] == 6'd31 || f[5:0] == 6'd32) begin
                        m_pc = m_pc + 15'd1;
                        e.bad = 1'b1;
                    end else begin
                        m_pc = 15'(m_pc + {9'b0, f[5:0]} - 15'd31);
                    end
                end
                3'd2: m_pc = {m_pc[14:12], f[11:0]};
                3'd3: m_pc = f;
                3'd4: begin
                    m_busy = 1'b1;
                    e.tadr = {m_pc[14:8], a};
                    e.chk_tadr = 1'b1;
                end
                default: ;
            endcase
        end
        e.pc = m_pc;
        e.busy = m_busy;
        sb_q.push_back(e);
    endtask

    // monitor: compares 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "pc", pc, e.pc);
                check(e.req, "busy", 15'(busy), 15'(e.busy));
                check(e.req, "bad_disp", 15'(bad_disp), 15'(e.bad));
                if (e.chk_tadr) check(e.req, "tbl_addr", tbl_addr, e.tadr);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "pc", pc, 15'h0);
        check("R1", "busy", 15'(busy), 15'h0);
        check("R1", "bad_disp", 15'(bad_disp), 15'h0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 3'd0, 15'h0, 8'h0, 8'h0, "R3");
        step(1, 3'd0, 15'h0, 8'h0, 8'h0, "R3");
        step(0, 3'd0, 15'h1234, 8'h0, 8'h0, "R2");
        step(0, 3'd3, 15'h5555, 8'h0, 8'h0, "R2");
        step(1, 3'd3, 15'h7FFF, 8'h0, 8'h0, "R7");
        step(1, 3'd0, 15'h0, 8'h0, 8'h0, "R3 wrap");
        step(1, 3'd3, 15'h00F0, 8'h0, 8'h0, "R7");
        step(1, 3'd1, 15'd63, 8'h0, 8'h0, "R4 +32 page cross");
        step(1, 3'd1, 15'd0, 8'h0, 8'h0, "R4 -31");
        step(1, 3'd3, 15'h0005, 8'h0, 8'h0, "R7");
        step(1, 3'd1, 15'd0, 8'h0, 8'h0, "R4 wrap below zero");
        step(1, 3'd1, 15'h7FE1, 8'h0, 8'h0, "R4 upper field bits ignored");
        step(1, 3'd1, 15'd31, 8'h0, 8'h0, "R5 offset 0");
        step(1, 3'd1, 15'd32, 8'h0, 8'h0, "R5 offset +1");
        step(1, 3'd0, 15'h0, 8'h0, 8'h0, "R5 flag clears");
        step(1, 3'd3, 15'h5ABC, 8'h0, 8'h0, "R7");
        step(1, 3'd2, 15'h7123, 8'h0, 8'h0, "R6");
        step(1, 3'd5, 15'h1111, 8'h0, 8'h0, "R11");
        step(1, 3'd7, 15'h2222, 8'h0, 8'h0, "R11");
        step(1, 3'd4, 15'h0, 8'h3C, 8'h0, "R8");
        step(1, 3'd3, 15'h0777, 8'hFF, 8'hA5, "R9 R10");
        step(1, 3'd3, 15'h4321, 8'h0, 8'h0, "R7");
        step(1, 3'd4, 15'h0, 8'hFF, 8'h0, "R8");
        step(0, 3'd0, 15'h0, 8'h0, 8'h00, "R9");
        step(1, 3'd4, 15'h0, 8'h01, 8'h0, "R8 back to back");
        step(1, 3'd0, 15'h0, 8'h0, 8'h7E, "R10");
        step(0, 3'd0, 15'h0, 8'h0, 8'h0, "R2");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule